// File: doc/BRIEF.md
# Residue-field radix-2 delay-feedback butterfly stage

This block is one stage of a serial pipelined radix-2 decimation-in-frequency FFT whose arithmetic is done in a single residue channel, modulo a small prime `P`. One residue sample enters on every clock. The stage pairs each sample with the one that arrived `HALF = N >> (STAGE+1)` clocks earlier. It keeps the earlier sample in a feedback delay line of `HALF` clocks, built as a shift register of `HALF-1` words followed by one pipeline register.

A small counter, reset to zero, splits the stream into groups of `2*HALF` samples. In the first half of a group (store phase) the incoming sample enters the delay line, and the stage emits what leaves the delay line multiplied by a twiddle constant. In the second half (combine phase) the stage emits the modular sum of the delayed and incoming samples, and writes their modular difference back into the delay line. That difference leaves the line during the store phase of the next group. The twiddle constant is picked by the counter's low bits from a table computed at elaboration as `ROOT^(k * 2^STAGE) mod P`. All results are reduced modulo `P` and the output is registered.

Top module: `rbf_stage`

## Requirements
- R1: While `rst` is high at a clock edge, `dout` becomes 0 and the delay line is cleared. The first sample captured after `rst` falls is sample index 0 of group 0. A reset in mid-stream has the same effect.
- R2: `dout` always lies in the range 0 to `P-1`.
- R3: Let `pos = t mod 2*HALF` for the sample `x[t]` captured at edge `t`. If `pos >= HALF`, the value of `dout` after that edge is `(x[t-HALF] + x[t]) mod P`.
- R4: If `pos < HALF` and `t >= 2*HALF`, the value of `dout` after edge `t` is `((x[t-2*HALF] - x[t-HALF]) mod P) * c(pos) mod P`. This is the stored difference of the previous group.
- R5: The twiddle constant is `c(k) = ROOT^(k * 2^STAGE) mod P`, so `c(0) = 1`, and a store-phase output with `pos = 0` equals the stored difference unchanged.
- R6: The latency is `HALF + 1` clocks: the first sum of a group appears after the edge that captures that group's sample `HALF`, one register after it.
- R7: In the store phase of group 0 after reset, `dout` is 0, because the delay line holds zeros.
- R8: A difference whose subtrahend is larger wraps: `x[a] - x[b]` becomes `x[a] - x[b] + P`.
- R9: A sum of `P` or more wraps: `x[a] + x[b]` becomes `x[a] + x[b] - P`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; one sample per rising edge |
| rst | input | 1 | Synchronous active-high reset |
| din | input | RW = $clog2(P) | Input residue, 0 to P-1 |
| dout | output | RW | Registered output residue |

## Verification
The assertions check four things on every clock. The output and the reduced product always stay inside the field. A combine-phase output equals the modular sum of the fed-back word and the input seen one clock earlier. A store-phase output at position zero equals the fed-back word unchanged. A zero operand gives a zero twiddle product. Only the bench's scenarios can show the rest: that the delay line holds exactly `HALF` clocks, that stored differences return in the right slot of the next group with the right twiddle constant, that sums and differences wrap at the field edge, and that reset clears state in mid-stream.

// File: rtl/rbf_pkg.sv
package rbf_pkg;

  // Modular power by repeated multiplication; used only at elaboration.
  function automatic int unsigned rbf_pow(input int unsigned base,
                                          input int unsigned expo,
                                          input int unsigned modulus);
    int unsigned acc;
    int unsigned b;
    acc = 1 % modulus;
    b   = base % modulus;
    for (int unsigned i = 0; i < expo; i++) begin
      acc = (acc * b) % modulus;
    end
    return acc;
  endfunction

  // Phase of the current group as seen by one stage.
  typedef enum logic {
    PH_STORE   = 1'b0,
    PH_COMBINE = 1'b1
  } rbf_phase_e;

endpackage

// File: rtl/rbf_ctrl.sv
module rbf_ctrl #(
  parameter int HB = 4,                 // log2 of half group length
  parameter int KW = (HB > 0) ? HB : 1  // width of position index
) (
  input  logic                 clk,
  input  logic                 rst,
  output rbf_pkg::rbf_phase_e  phase,
  output logic [KW-1:0]        pos
);
  localparam int CBW = HB + 1;

  logic [CBW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) cnt <= '0;
    else     cnt <= cnt + 1'b1;
  end

  assign phase = rbf_pkg::rbf_phase_e'(cnt[HB]);

  generate
    if (HB > 0) begin : g_pos
      assign pos = cnt[KW-1:0];
    end else begin : g_pos0
      assign pos = '0;
    end
  endgenerate

endmodule

// File: rtl/rbf_delay.sv
module rbf_delay #(
  parameter int RW    = 6,
  parameter int DEPTH = 15
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] d_in,
  output logic [RW-1:0] d_out
);
  generate
    if (DEPTH == 0) begin : g_none
      assign d_out = d_in;
    end else begin : g_shift
      logic [RW-1:0] taps [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) taps[i] <= '0;
        end else begin
          taps[0] <= d_in;
          for (int i = 1; i < DEPTH; i++) taps[i] <= taps[i-1];
        end
      end
      assign d_out = taps[DEPTH-1];
    end
  endgenerate

endmodule

// File: rtl/rbf_modred.sv
module rbf_modred #(
  parameter int P  = 61,
  parameter int RW = 6,
  parameter int IW = 2 * RW
) (
  input  logic [IW-1:0] v,
  output logic [RW-1:0] r
);
  // Restoring reduction: try P<<(RW-1) down to P<<0.
  logic [IW-1:0] st [RW+1];

  assign st[0] = v;

  generate
    for (genvar i = 0; i < RW; i++) begin : g_step
      localparam logic [IW-1:0] SUBV = IW'(P) << (RW - 1 - i);
      assign st[i+1] = (st[i] >= SUBV) ? (st[i] - SUBV) : st[i];
    end
  endgenerate

  assign r = st[RW][RW-1:0];

  always_comb begin
    if (!$isunknown(v)) begin
      AST_RED_RANGE: assert (st[RW] < IW'(P)); // R2
    end
  end

endmodule

// File: rtl/rbf_twiddle.sv
module rbf_twiddle #(
  parameter int P     = 61,
  parameter int RW    = 6,
  parameter int ROOT  = 2,
  parameter int STAGE = 1,
  parameter int HB    = 4,
  parameter int KW    = (HB > 0) ? HB : 1
) (
  input  logic [KW-1:0] pos,
  input  logic [RW-1:0] val,
  output logic [RW-1:0] prod
);
  import rbf_pkg::*;

  localparam int HALF = 1 << HB;
  localparam int IW   = 2 * RW;

  logic [RW-1:0] tab [HALF];
  logic [RW-1:0] coef;
  logic [IW-1:0] wide;

  generate
    for (genvar i = 0; i < HALF; i++) begin : g_tab
      assign tab[i] = RW'(rbf_pow(ROOT, i << STAGE, P));
    end
    if (HB > 0) begin : g_sel
      assign coef = tab[pos];
    end else begin : g_sel0
      assign coef = tab[0];
    end
  endgenerate

  assign wide = {{RW{1'b0}}, val} * {{RW{1'b0}}, coef};

  rbf_modred #(.P(P), .RW(RW), .IW(IW)) u_red (
    .v (wide),
    .r (prod)
  );

  always_comb begin
    if (!$isunknown(val) && !$isunknown(prod) && (val == '0)) begin
      AST_TW_ZERO: assert (prod == '0); // R4
    end
  end

endmodule

// File: rtl/rbf_stage.sv
module rbf_stage #(
  parameter int N     = 64,
  parameter int STAGE = 1,
  parameter int P     = 61,
  parameter int ROOT  = 2,
  parameter int RW    = $clog2(P)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [RW-1:0] din,
  output logic [RW-1:0] dout
);
  import rbf_pkg::*;

  localparam int HALF = N >> (STAGE + 1);
  localparam int HB   = $clog2(HALF);
  localparam int KW   = (HB > 0) ? HB : 1;
  localparam int SRD  = HALF - 1;
  localparam logic [RW:0] P_EXT = (RW+1)'(P);

  rbf_phase_e    phase;
  logic [KW-1:0] pos;
  logic [RW-1:0] fb_in, sr_out, fb_q;
  logic [RW-1:0] sum_r, diff_r, tw_r;

  rbf_ctrl #(.HB(HB), .KW(KW)) u_ctrl (
    .clk   (clk),
    .rst   (rst),
    .phase (phase),
    .pos   (pos)
  );

  // Modular add and subtract of two field elements.
  always_comb begin
    logic [RW:0] s;
    s     = {1'b0, fb_q} + {1'b0, din};
    sum_r = (s >= P_EXT) ? RW'(s - P_EXT) : RW'(s);
  end

  always_comb begin
    logic [RW:0] d;
    if (fb_q >= din) d = {1'b0, fb_q} - {1'b0, din};
    else             d = {1'b0, fb_q} + P_EXT - {1'b0, din};
    diff_r = d[RW-1:0];
  end

  assign fb_in = (phase == PH_COMBINE) ? diff_r : din;

  rbf_delay #(.RW(RW), .DEPTH(SRD)) u_delay (
    .clk   (clk),
    .rst   (rst),
    .d_in  (fb_in),
    .d_out (sr_out)
  );

  // Last clock of the feedback delay.
  always_ff @(posedge clk) begin
    if (rst) fb_q <= '0;
    else     fb_q <= sr_out;
  end

  rbf_twiddle #(
    .P(P), .RW(RW), .ROOT(ROOT), .STAGE(STAGE), .HB(HB), .KW(KW)
  ) u_tw (
    .pos  (pos),
    .val  (fb_q),
    .prod (tw_r)
  );

  always_ff @(posedge clk) begin
    if (rst)                      dout <= '0;
    else if (phase == PH_COMBINE) dout <= sum_r;
    else                          dout <= tw_r;
  end

  AST_OUT_RANGE: assert property (@(posedge clk) disable iff (rst)
    dout < RW'(P)); // R2

  AST_SUM_PATH: assert property (@(posedge clk) disable iff (rst)
    (phase == PH_COMBINE) |=>
      (int'(dout) == ((int'($past(fb_q)) + int'($past(din))) % P))); // R3

  AST_UNITY_COEF: assert property (@(posedge clk) disable iff (rst)
    ((phase == PH_STORE) && (pos == '0)) |=> (dout == $past(fb_q))); // R5

endmodule

// File: tb/rbf_stage_bench.sv
`timescale 1ns/1ps
module rbf_stage_bench;
  localparam int N    = 64;
  localparam int S    = 1;
  localparam int P    = 61;
  localparam int ROOT = 2;
  localparam int RW   = $clog2(P);
  localparam int H    = N >> (S + 1);
  localparam int T    = 8 * H;

  localparam int TBL [32] = '{3, 17, 42, 0, 60, 11, 29, 54, 8, 33, 47, 21, 5, 38, 59, 14,
                              26, 1, 50, 19, 44, 7, 36, 58, 12, 31, 2, 49, 23, 40, 9, 55};

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [RW-1:0] din = '0;
  logic [RW-1:0] dout;

  int checks = 0;
  int errors = 0;
  int xs [T];
  int tw [H];

  always #2.5 clk = ~clk;

  rbf_stage #(.N(N), .STAGE(S), .P(P), .ROOT(ROOT)) u_rbf_stage (
    .clk  (clk),
    .rst  (rst),
    .din  (din),
    .dout (dout)
  );

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int stim(input int mode, input int t);
    int g, p2, pos;
    g   = t / (2 * H);
    p2  = t % 32;
    pos = t % (2 * H);
    if (mode == 0) begin
      if (g == 1)      return (P - 1) - TBL[31 - p2];
      else if (g == 2) return (TBL[p2] * 7 + g) % P;
      else             return TBL[p2];
    end
    // wrap pattern: second half at P-1, first half mixes 0 and P-1
    if (pos >= H) return P - 1;
    return (pos % 3 == 0) ? 0 : P - 1;
  endfunction

  task automatic run(input int mode);
    int e, pos;
    string tag;
    rst = 1'b1;
    din = '0;
    repeat (2) @(negedge clk);
    check("R1", int'(dout), 0);
    for (int t = 0; t < T; t++) xs[t] = stim(mode, t);
    rst = 1'b0;
    din = RW'(xs[0]);
    for (int t = 0; t < T; t++) begin
      @(negedge clk);
      pos = t % (2 * H);
      if (pos >= H) begin
        e = (xs[t-H] + xs[t]) % P;
        if (t == H)                    tag = "R6";
        else if (xs[t-H] + xs[t] >= P) tag = "R9";
        else                           tag = "R3";
      end else if (t < H) begin
        e = 0;
        tag = "R7";
      end else begin
        e = (((xs[t-2*H] - xs[t-H] + P) % P) * tw[pos]) % P;
        if (pos == 0)                   tag = "R5";
        else if (xs[t-2*H] < xs[t-H])   tag = "R8";
        else                            tag = "R4";
      end
      check(tag, int'(dout), e);
      if (int'(dout) >= P) check("R2", int'(dout), P - 1);
      din = (t + 1 < T) ? RW'(xs[t+1]) : '0;
    end
  endtask

  initial begin
    int step;
    // step = ROOT^(2^S) by repeated squaring, then powers of it
    step = ROOT % P;
    for (int i = 0; i < S; i++) step = (step * step) % P;
    tw[0] = 1;
    for (int k = 1; k < H; k++) tw[k] = (tw[k-1] * step) % P;

    check("R5", tw[0], 1);
    run(0);
    run(1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #1_000_000;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule